// File: doc/BRIEF.md
# Prioritized Edge-Triggered Interrupt Controller

The block watches three external interrupt request lines. Each line passes through a two-flop synchronizer. A rising edge on a line sets a sticky pending flag for that line. The flag is set whether interrupts are enabled or not, and a line held high counts as one request only.

When the core reports the end of an instruction, interrupts are enabled and at least one flag is pending, the controller accepts the highest-priority request. Line 0 has the highest priority and line 2 the lowest. It then runs a fixed two-cycle entry. In the first cycle it asks the core to push the program counter that was captured at acceptance onto the return stack. In the second cycle it presents the vector index of the accepted line. Acceptance clears the global enable. Only an explicit enable command from software sets it again.

Top module: `irq_ctrl`

## Requirements
- R1: After reset, push_o, vec_valid_o and busy_o are 0, vec_sel_o is 0, no request is pending and interrupts are disabled.
- R2: A rising edge on irq_req_i[n] is synchronized through two flops and latched as pending, so that an instruction end seen at the fourth rising clock edge after the input rise can accept it, while earlier ones cannot.
- R3: A request is accepted only at a clock edge where instr_end_i is 1, interrupts are enabled and the controller is idle; without instr_end_i, pending requests wait indefinitely.
- R4: Entry lasts exactly two cycles with busy_o high in both: first push_o=1 with push_pc_o equal to pc_i at the accepting edge, then vec_valid_o=1; busy_o returns to 0 in the next cycle.
- R5: Among pending requests, line 0 wins over line 1, which wins over line 2.
- R6: Acceptance clears only the accepted line's pending flag; lower-priority pending requests stay pending and are taken on later entries.
- R7: Acceptance disables interrupts; no further entry happens until ien_set_i has been 1 at a clock edge.
- R8: Rising edges that arrive while interrupts are disabled are latched and taken once interrupts are enabled again.
- R9: A line held high produces a single request, and it gives no new request until it has gone low and risen again.
- R10: vec_sel_o is the binary number of the accepted line (0, 1 or 2) while vec_valid_o is 1 and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_req_i | input | 3 | Raw interrupt request lines, rising-edge sensitive |
| instr_end_i | input | 1 | Strobe for the last cycle of an instruction |
| ien_set_i | input | 1 | Command that sets the global interrupt enable |
| pc_i | input | 16 | Current program counter |
| push_o | output | 1 | Return-stack push strobe (first entry cycle) |
| push_pc_o | output | 16 | Value to push, the PC captured at acceptance |
| vec_valid_o | output | 1 | Vector load strobe (second entry cycle) |
| vec_sel_o | output | 2 | Index of the accepted line |
| busy_o | output | 1 | Entry sequence in progress |

## Verification
The bench raises several lines at once and checks the order of service. A design with a wrong priority, or one that drops all pending flags on acceptance, would present the wrong vector or skip the leftover lines. It then sends an instruction end without an enable after an entry. A design that does not clear the enable would re-enter here. It raises an edge while interrupts are off, which a design that gates edge capture with the enable would lose. It holds a line high across an entry, which a level-sensitive design would take twice. It also pulses instr_end_i during the synchronizer latency to check that a request cannot be accepted before it has passed through the synchronizer.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PUSH = 2'd1,
    ST_VEC  = 2'd2
  } irq_state_e;
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter int unsigned N      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] rise_o
);
  for (genvar g = 0; g < N; g++) begin : g_line
    // chain[STAGES-1] is the synchronized level, chain[STAGES] its delayed copy
    logic [STAGES:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-1:0], req_i[g]};
    end
    assign rise_o[g] = chain_q[STAGES-1] & ~chain_q[STAGES];
  end
endmodule

// File: rtl/irq_pending.sv
module irq_pending #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] rise_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] pend_q;

  // a fresh edge wins over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr_i) | rise_i;
  end
  assign pend_o = pend_q;

  // R6
  clr_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i & ~pend_q) == '0);
endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
  parameter int unsigned N     = 3,
  parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     pend_i,
  output logic [N-1:0]     grant_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  always_comb begin
    grant_o = '0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        grant_o    = '0;
        grant_o[i] = 1'b1;
        idx_o      = IDX_W'(i);
      end
    end
  end
  assign any_o = |pend_i;
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_pkg::*;
#(
  parameter int unsigned N     = 3,
  parameter int unsigned PC_W  = 16,
  parameter int unsigned IDX_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             instr_end_i,
  input  logic             ien_set_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic             any_i,
  input  logic [N-1:0]     grant_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [N-1:0]     ack_o,
  output logic             push_o,
  output logic [PC_W-1:0]  push_pc_o,
  output logic             vec_valid_o,
  output logic [IDX_W-1:0] vec_sel_o,
  output logic             busy_o
);
  irq_state_e       state_q, state_d;
  logic             ien_q;
  logic             take;
  logic [PC_W-1:0]  pc_q;
  logic [IDX_W-1:0] idx_q;

  assign take  = (state_q == ST_IDLE) & instr_end_i & ien_q & any_i;
  assign ack_o = take ? grant_i : '0;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (take) state_d = ST_PUSH;
      ST_PUSH: state_d = ST_VEC;
      ST_VEC:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ien_q   <= 1'b0;
      pc_q    <= '0;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      if (take)           ien_q <= 1'b0;
      else if (ien_set_i) ien_q <= 1'b1;
      if (take) begin
        pc_q  <= pc_i;
        idx_q <= idx_i;
      end
    end
  end

  assign push_o      = (state_q == ST_PUSH);
  assign push_pc_o   = push_o ? pc_q : '0;
  assign vec_valid_o = (state_q == ST_VEC);
  assign vec_sel_o   = vec_valid_o ? idx_q : '0;
  assign busy_o      = (state_q != ST_IDLE);

  // R3
  entry_at_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(instr_end_i));
  // R4
  push_then_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |=> vec_valid_o);
  // R4
  push_pc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(push_o) |-> push_pc_o == $past(pc_i));
  // R4
  vec_ends_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |=> !busy_o);
  // R7
  ien_cleared_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |-> !ien_q);
  // R10
  vec_idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vec_valid_o |-> vec_sel_o == '0);
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl #(
  parameter int unsigned N_IRQ       = 3,
  parameter int unsigned PC_W        = 16,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned IDX_W      = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_IRQ-1:0] irq_req_i,
  input  logic             instr_end_i,
  input  logic             ien_set_i,
  input  logic [PC_W-1:0]  pc_i,
  output logic             push_o,
  output logic [PC_W-1:0]  push_pc_o,
  output logic             vec_valid_o,
  output logic [IDX_W-1:0] vec_sel_o,
  output logic             busy_o
);
  logic [N_IRQ-1:0] rise, pend, grant, ack;
  logic [IDX_W-1:0] idx;
  logic             any;

  irq_edge_det #(.N(N_IRQ), .STAGES(SYNC_STAGES)) u_edge (
    .clk_i, .rst_ni, .req_i(irq_req_i), .rise_o(rise)
  );

  irq_pending #(.N(N_IRQ)) u_pend (
    .clk_i, .rst_ni, .rise_i(rise), .clr_i(ack), .pend_o(pend)
  );

  irq_prio #(.N(N_IRQ), .IDX_W(IDX_W)) u_prio (
    .pend_i(pend), .grant_o(grant), .idx_o(idx), .any_o(any)
  );

  irq_entry_seq #(.N(N_IRQ), .PC_W(PC_W), .IDX_W(IDX_W)) u_seq (
    .clk_i, .rst_ni, .instr_end_i, .ien_set_i, .pc_i,
    .any_i(any), .grant_i(grant), .idx_i(idx), .ack_o(ack),
    .push_o, .push_pc_o, .vec_valid_o, .vec_sel_o, .busy_o
  );

  // R5
  ack_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ack));
  // R5
  ack_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack != '0 |-> (((ack - 1'b1) & pend) == '0));
endmodule

// File: tb/irq_ctrl_test.sv
module irq_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;
  // {raise mask, expected vector}
  localparam logic [4:0] VECS [NV] = '{
    {3'b001, 2'd0}, {3'b010, 2'd1}, {3'b100, 2'd2}, {3'b110, 2'd1},
    {3'b000, 2'd2}, {3'b111, 2'd0}, {3'b000, 2'd1}, {3'b000, 2'd2},
    {3'b101, 2'd0}, {3'b000, 2'd2}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  req = '0;
  logic        iend = 1'b0;
  logic        iset = 1'b0;
  logic [15:0] pc = '0;
  logic        push, vvalid, busy;
  logic [15:0] push_pc;
  logic [1:0]  vsel;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  irq_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .irq_req_i(req), .instr_end_i(iend),
    .ien_set_i(iset), .pc_i(pc), .push_o(push), .push_pc_o(push_pc),
    .vec_valid_o(vvalid), .vec_sel_o(vsel), .busy_o(busy)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string req_id, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req_id, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_lines(input logic [2:0] m);
    req = m;
    cyc(1);
    req = '0;
    cyc(4);
  endtask

  // enable, then one instruction end, then check the two entry cycles
  task automatic enter(input logic [1:0] exp_vec, input logic [15:0] exp_pc, input string rid);
    iset = 1'b1;
    cyc(1);
    iset = 1'b0;
    iend = 1'b1;
    pc = exp_pc;
    cyc(1);
    iend = 1'b0;
    chk({rid, "/R4 push"}, 32'(push), 32'd1);
    chk({rid, "/R4 pc"}, 32'(push_pc), 32'(exp_pc));
    chk({rid, "/R4 busy1"}, 32'(busy), 32'd1);
    cyc(1);
    chk({rid, "/R4 vec"}, 32'(vvalid), 32'd1);
    chk({rid, "/R10 sel"}, 32'(vsel), 32'(exp_vec));
    chk({rid, "/R4 busy2"}, 32'(busy), 32'd1);
    cyc(1);
    chk({rid, "/R4 idle"}, 32'(busy), 32'd0);
  endtask

  initial begin
    cyc(2);
    chk("R1 push", 32'(push), 32'd0);
    chk("R1 vec", 32'(vvalid), 32'd0);
    chk("R1 busy", 32'(busy), 32'd0);
    chk("R10 sel", 32'(vsel), 32'd0);
    rst_n = 1'b1;
    cyc(2);
    // R1: disabled after reset, pending edge not taken without an enable
    req = 3'b001;
    cyc(4);
    iend = 1'b1;
    cyc(3);
    iend = 1'b0;
    chk("R1 disabled", 32'(busy), 32'd0);
    req = '0;
    enter(2'd0, 16'h0100, "R8");

    // R5 R6 table
    for (int i = 0; i < NV; i++) begin
      pulse_lines(VECS[i][4:2]);
      enter(VECS[i][1:0], 16'(16'h1000 + i * 16'h0111), "R5R6");
    end

    // R3: pending, enabled, no instruction end -> waits
    pulse_lines(3'b010);
    iset = 1'b1;
    cyc(1);
    iset = 1'b0;
    cyc(6);
    chk("R3 wait", 32'(busy), 32'd0);
    iend = 1'b1;
    pc = 16'h2222;
    cyc(1);
    iend = 1'b0;
    chk("R3 take", 32'(push), 32'd1);
    cyc(1);
    chk("R3 vec", 32'(vsel), 32'd1);
    cyc(1);

    // R7: after entry, instruction end without enable does nothing
    pulse_lines(3'b100);
    iend = 1'b1;
    cyc(4);
    iend = 1'b0;
    chk("R7 no reentry", 32'(busy), 32'd0);
    enter(2'd2, 16'h3333, "R7");

    // R2: sync latency; instr_end held, enabled
    iset = 1'b1;
    cyc(1);
    iset = 1'b0;
    iend = 1'b1;
    pc = 16'h4444;
    req = 3'b001;
    cyc(3);
    chk("R2 early", 32'(busy), 32'd0);
    cyc(1);
    iend = 1'b0;
    chk("R2 take", 32'(push), 32'd1);
    chk("R2 pc", 32'(push_pc), 32'h4444);
    cyc(2);

    // R9: line 0 still held high since the previous step; no new request
    iset = 1'b1;
    cyc(1);
    iset = 1'b0;
    iend = 1'b1;
    cyc(6);
    iend = 1'b0;
    chk("R9 level", 32'(busy), 32'd0);
    req = '0;
    cyc(3);
    pulse_lines(3'b001);
    enter(2'd0, 16'h5555, "R9");

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        cyc(5000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule